// File: doc/BRIEF.md
# Multiplexed-Bin Power Statistics Integrator

The block integrates complex product statistics over a stream in which frequency bins arrive time-multiplexed in a fixed repeating order. Every valid input pair (a, b) is multiplied as a times the conjugate of b. The product is added to the running total of the bin that the sample belongs to. The totals live in an internal memory with a two-cycle read latency, which is updated by read-modify-write. The bin index is a free-running counter. It steps once per valid sample and wraps after the last bin.

A single-cycle sync pulse closes the current integration interval. The block does not run a separate sweep to dump or clear the memory. When a bin receives its first sample of the new interval, the pipeline reads the finished total and emits it on the output with the bin number and a one-cycle strobe. In the same cycle it loads the new product in place of the old total. In auto-power mode the caller feeds the same sample to both inputs and only the real total is produced. In cross mode both the real and the imaginary totals are kept.

Top module: `statint_power_integrator`

## Requirements
- R1: The bin counter starts at 0 after reset. It advances by one on each cycle with `in_valid` high and wraps from `N_BINS-1` to 0. A report carries in `out_bin` the bin that its triggering sample fell on.
- R2: Each accumulated product is re = ar·br + ai·bi and im = ai·br − ar·bi, on signed inputs. The product is sign-extended to `ACC_W` bits and summed modulo 2^`ACC_W`.
- R3: `in_sync` closes the interval whether or not `in_valid` is high in that cycle. A valid sample presented together with `in_sync` counts toward the new interval.
- R4: Valid samples that arrive before the first sync after reset are not accumulated. No report appears until an interval opened by a sync has itself been closed.
- R5: A bin that collected at least one sample in the previous interval is reported exactly once, on the first valid sample of that bin in the next interval. `out_valid` is high for one cycle, 4 clock edges after the input cycle of that sample, and `out_re`/`out_im` carry the finished totals.
- R6: The first sample of a bin in an interval replaces that bin's total. Nothing from earlier intervals carries over.
- R7: A bin that received no sample in an interval produces no report. A finished total that is not claimed before the next sync is dropped.
- R8: With `COMPLEX_EN` = 0, `out_im` is always zero.
- R9: The block is correct at `N_BINS` = 8, the smallest supported size. No pipeline stage ever reads a bin whose update is still in flight.
- R10: Synchronous active-high `rst` clears the bin counter, the interval bookkeeping and `out_valid`.
- R11: Cycles with `in_valid` low change no total and do not move the bin counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_sync | input | 1 | Interval-close pulse |
| in_a_re | input | IN_W | Real part of operand a (signed) |
| in_a_im | input | IN_W | Imaginary part of operand a (signed) |
| in_b_re | input | IN_W | Real part of operand b (signed) |
| in_b_im | input | IN_W | Imaginary part of operand b (signed) |
| out_valid | output | 1 | Report strobe |
| out_bin | output | $clog2(N_BINS) | Bin of the reported total |
| out_re | output | ACC_W | Real total of the finished interval |
| out_im | output | ACC_W | Imaginary total (zero in auto mode) |

## Verification
A report is due exactly 4 clock edges after the input cycle of the sample that claims it. One edge is the input register, two are the memory read latency, and one is the output register. The bench computes the expected report for each driven sample at drive time and stores it in an eight-entry ring. On every falling edge it compares the outputs with the entry written four cycles earlier, so each check lands on the same cycle on which the design's output changes. Quiet cycles are held to `out_valid` low by the same comparison.

// File: rtl/statint_pkg.sv
package statint_pkg;

    // Read latency of the accumulator memory; the pipeline is aligned to it.
    localparam int RAM_RD_LAT = 2;

    // Control bits that travel down the pipeline beside each sample.
    typedef struct packed {
        logic vld;
        logic syn;
    } ctl_t;

endpackage

// File: rtl/statint_bin_ctr.sv
module statint_bin_ctr #(
    parameter int N_BINS = 512,
    parameter int BIN_W  = $clog2(N_BINS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             advance,
    output logic [BIN_W-1:0] bin_o
);
    localparam logic [BIN_W-1:0] LAST_BIN = BIN_W'(N_BINS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            bin_o <= '0;
        end else if (advance) begin
            bin_o <= (bin_o == LAST_BIN) ? '0 : bin_o + BIN_W'(1);
        end
    end

    a_r1_bin_in_range: assert property (@(posedge clk) disable iff (rst)
        bin_o <= LAST_BIN);

    a_r11_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
        !advance |=> $stable(bin_o));

    a_r10_reset_bin_zero: assert property (@(posedge clk)
        rst |=> bin_o == '0);

endmodule

// File: rtl/statint_cmul.sv
module statint_cmul #(
    parameter int IN_W       = 18,
    parameter bit COMPLEX_EN = 1'b0,
    parameter int PW         = 2 * IN_W + 1
) (
    input  logic                   clk,
    input  logic signed [IN_W-1:0] a_re,
    input  logic signed [IN_W-1:0] a_im,
    input  logic signed [IN_W-1:0] b_re,
    input  logic signed [IN_W-1:0] b_im,
    output logic signed [PW-1:0]   p_re,
    output logic signed [PW-1:0]   p_im
);
    logic signed [PW-1:0] ar_x, ai_x, br_x, bi_x;
    logic signed [PW-1:0] re_c;

    assign ar_x = PW'(a_re);
    assign ai_x = PW'(a_im);
    assign br_x = PW'(b_re);
    assign bi_x = PW'(b_im);
    assign re_c = ar_x * br_x + ai_x * bi_x;

    always_ff @(posedge clk) begin
        p_re <= re_c;
    end

    generate
        if (COMPLEX_EN) begin : g_cross
            logic signed [PW-1:0] im_c;
            assign im_c = ai_x * br_x - ar_x * bi_x;
            always_ff @(posedge clk) begin
                p_im <= im_c;
            end
        end else begin : g_auto
            assign p_im = '0;
        end
    endgenerate

endmodule

// File: rtl/statint_acc_ram.sv
module statint_acc_ram #(
    parameter int DEPTH  = 512,
    parameter int ADDR_W = $clog2(DEPTH),
    parameter int DATA_W = 54,
    parameter int RD_LAT = statint_pkg::RAM_RD_LAT
) (
    input  logic              clk,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data
);
    logic [DATA_W-1:0] mem [DEPTH];
    logic [DATA_W-1:0] rd_pipe [RD_LAT];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_data;
        end
        rd_pipe[0] <= mem[rd_addr];
    end

    generate
        for (genvar s = 1; s < RD_LAT; s++) begin : g_rd_stage
            always_ff @(posedge clk) begin
                rd_pipe[s] <= rd_pipe[s-1];
            end
        end
    endgenerate

    assign rd_data = rd_pipe[RD_LAT-1];

endmodule

// File: rtl/statint_power_integrator.sv
module statint_power_integrator #(
    parameter int N_BINS     = 512,
    parameter int IN_W       = 18,
    parameter int ACC_W      = 54,
    parameter bit COMPLEX_EN = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    in_valid,
    input  logic                    in_sync,
    input  logic signed [IN_W-1:0]  in_a_re,
    input  logic signed [IN_W-1:0]  in_a_im,
    input  logic signed [IN_W-1:0]  in_b_re,
    input  logic signed [IN_W-1:0]  in_b_im,
    output logic                    out_valid,
    output logic [$clog2(N_BINS)-1:0] out_bin,
    output logic [ACC_W-1:0]        out_re,
    output logic [ACC_W-1:0]        out_im
);
    import statint_pkg::*;

    localparam int BIN_W = $clog2(N_BINS);
    localparam int PW    = 2 * IN_W + 1;

    // Stage 0: registered input; drives the memory read address.
    ctl_t                   s0_ctl, s1_ctl, s2_ctl;
    logic [BIN_W-1:0]       s0_bin, s1_bin, s2_bin;
    logic signed [IN_W-1:0] s0_ar, s0_ai, s0_br, s0_bi;
    logic [BIN_W-1:0]       cur_bin;

    statint_bin_ctr #(.N_BINS(N_BINS), .BIN_W(BIN_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .advance (in_valid),
        .bin_o   (cur_bin)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            s0_ctl <= '0;
            s1_ctl <= '0;
            s2_ctl <= '0;
        end else begin
            s0_ctl <= '{vld: in_valid, syn: in_sync};
            s1_ctl <= s0_ctl;
            s2_ctl <= s1_ctl;
        end
        s0_bin <= cur_bin;
        s1_bin <= s0_bin;
        s2_bin <= s1_bin;
        s0_ar  <= in_a_re;
        s0_ai  <= in_a_im;
        s0_br  <= in_b_re;
        s0_bi  <= in_b_im;
    end

    // Stage 1: product registered; stage 2: product held beside memory data.
    logic signed [PW-1:0] s1_pre, s1_pim;
    logic signed [PW-1:0] s2_pre, s2_pim;

    statint_cmul #(.IN_W(IN_W), .COMPLEX_EN(COMPLEX_EN), .PW(PW)) u_mul (
        .clk  (clk),
        .a_re (s0_ar),
        .a_im (s0_ai),
        .b_re (s0_br),
        .b_im (s0_bi),
        .p_re (s1_pre),
        .p_im (s1_pim)
    );

    always_ff @(posedge clk) begin
        s2_pre <= s1_pre;
        s2_pim <= s1_pim;
    end

    // Interval bookkeeping: cur = bin touched this interval,
    // prv = bin holds an unclaimed total of the previous interval.
    logic [N_BINS-1:0] cur_q, prv_q, cur_d, prv_d, cur_e, prv_e;
    logic              armed_q, armed_e;
    logic              take, first, claim;
    logic [ACC_W-1:0]  old_re, old_im, ext_re, ext_im, sum_re, sum_im;

    assign ext_re = {{(ACC_W-PW){s2_pre[PW-1]}}, s2_pre};
    assign ext_im = {{(ACC_W-PW){s2_pim[PW-1]}}, s2_pim};

    always_comb begin
        cur_e   = s2_ctl.syn ? '0    : cur_q;
        prv_e   = s2_ctl.syn ? cur_q : prv_q;
        armed_e = armed_q | s2_ctl.syn;
        take    = s2_ctl.vld & armed_e;
        first   = ~cur_e[s2_bin];
        claim   = take & first & prv_e[s2_bin];
        cur_d   = cur_e;
        prv_d   = prv_e;
        if (take) begin
            cur_d[s2_bin] = 1'b1;
            prv_d[s2_bin] = 1'b0;
        end
        sum_re = first ? ext_re : old_re + ext_re;
        sum_im = first ? ext_im : old_im + ext_im;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q   <= '0;
            prv_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            cur_q   <= cur_d;
            prv_q   <= prv_d;
            armed_q <= armed_e;
        end
    end

    statint_acc_ram #(.DEPTH(N_BINS), .ADDR_W(BIN_W), .DATA_W(ACC_W)) u_ram_re (
        .clk     (clk),
        .rd_addr (s0_bin),
        .rd_data (old_re),
        .wr_en   (take),
        .wr_addr (s2_bin),
        .wr_data (sum_re)
    );

    generate
        if (COMPLEX_EN) begin : g_im_ram
            statint_acc_ram #(.DEPTH(N_BINS), .ADDR_W(BIN_W), .DATA_W(ACC_W)) u_ram_im (
                .clk     (clk),
                .rd_addr (s0_bin),
                .rd_data (old_im),
                .wr_en   (take),
                .wr_addr (s2_bin),
                .wr_data (sum_im)
            );
        end else begin : g_no_im
            assign old_im = '0;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
        end else begin
            out_valid <= claim;
        end
        out_bin <= s2_bin;
        out_re  <= old_re;
        out_im  <= COMPLEX_EN ? old_im : '0;
    end

    // Assertions beside the guarded logic.
    a_r5_report_from_sample: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(s2_ctl.vld));

    a_r4_quiet_until_armed: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> armed_q);

    a_r8_auto_im_zero: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (COMPLEX_EN || out_im == '0));

    a_r9_no_hazard_s1: assert property (@(posedge clk) disable iff (rst)
        (s2_ctl.vld && s1_ctl.vld) |-> s2_bin != s1_bin);

    a_r9_no_hazard_s0: assert property (@(posedge clk) disable iff (rst)
        (s2_ctl.vld && s0_ctl.vld) |-> s2_bin != s0_bin);

    a_r10_reset_quiet: assert property (@(posedge clk)
        rst |=> !out_valid);

endmodule

// File: tb/statint_power_integrator_tb_top.sv
module statint_power_integrator_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int IN_W  = 18;
    localparam int ACC_W = 54;
    localparam int NB0   = 8;
    localparam int NB1   = 12;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic in_sync  = 1'b0;
    logic signed [IN_W-1:0] ar = '0, ai = '0, br = '0, bi = '0;

    logic             v0, v1;
    logic [2:0]       bin0;
    logic [3:0]       bin1;
    logic [ACC_W-1:0] re0, im0, re1, im1;

    always #(CLK_PERIOD/2) clk = ~clk;

    statint_power_integrator #(.N_BINS(NB0), .IN_W(IN_W), .ACC_W(ACC_W), .COMPLEX_EN(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sync(in_sync),
        .in_a_re(ar), .in_a_im(ai), .in_b_re(br), .in_b_im(bi),
        .out_valid(v0), .out_bin(bin0), .out_re(re0), .out_im(im0));

    statint_power_integrator #(.N_BINS(NB1), .IN_W(IN_W), .ACC_W(ACC_W), .COMPLEX_EN(1'b0)) dut_auto_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_sync(in_sync),
        .in_a_re(ar), .in_a_im(ai), .in_b_re(ar), .in_b_im(ai),
        .out_valid(v1), .out_bin(bin1), .out_re(re1), .out_im(im1));

    int checks = 0;
    int errors = 0;
    int j = 0;
    string phase = "R2";
    int rep_obs [2];

    // Reference state per model (0: cross, 8 bins; 1: auto, 12 bins)
    bit               m_cur   [2][16];
    bit               m_prv   [2][16];
    logic [ACC_W-1:0] m_re    [2][16];
    logic [ACC_W-1:0] m_im    [2][16];
    bit               m_armed [2];
    int               m_bin   [2];

    bit               e_v   [2][8];
    int               e_bin [2][8];
    logic [ACC_W-1:0] e_re  [2][8];
    logic [ACC_W-1:0] e_im  [2][8];

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic signed [IN_W-1:0] rval();
        int unsigned r = $urandom % 16;
        if (r == 0) return {1'b1, {(IN_W-1){1'b0}}};
        if (r == 1) return {1'b0, {(IN_W-1){1'b1}}};
        return IN_W'($urandom);
    endfunction

    task automatic model(input int m, input bit v, input bit s, input int slot);
        int nb = (m == 0) ? NB0 : NB1;
        longint pre, pim;
        int b;
        if (m == 0) begin
            pre = longint'(ar) * longint'(br) + longint'(ai) * longint'(bi);
            pim = longint'(ai) * longint'(br) - longint'(ar) * longint'(bi);
        end else begin
            pre = longint'(ar) * longint'(ar) + longint'(ai) * longint'(ai);
            pim = 0;
        end
        e_v[m][slot] = 1'b0;
        if (s) begin
            m_armed[m] = 1'b1;
            for (int k = 0; k < 16; k++) begin
                m_prv[m][k] = m_cur[m][k];
                m_cur[m][k] = 1'b0;
            end
        end
        if (v) begin
            b = m_bin[m];
            m_bin[m] = (b == nb - 1) ? 0 : b + 1;
            if (m_armed[m]) begin
                if (!m_cur[m][b]) begin
                    if (m_prv[m][b]) begin
                        e_v[m][slot]   = 1'b1;
                        e_bin[m][slot] = b;
                        e_re[m][slot]  = m_re[m][b];
                        e_im[m][slot]  = m_im[m][b];
                    end
                    m_re[m][b] = ACC_W'(pre);
                    m_im[m][b] = ACC_W'(pim);
                end else begin
                    m_re[m][b] = m_re[m][b] + ACC_W'(pre);
                    m_im[m][b] = m_im[m][b] + ACC_W'(pim);
                end
                m_cur[m][b] = 1'b1;
                m_prv[m][b] = 1'b0;
            end
        end
    endtask

    task automatic compare(input int m, input int slot);
        logic             av = (m == 0) ? v0 : v1;
        int               ab = (m == 0) ? int'(bin0) : int'(bin1);
        logic [ACC_W-1:0] are = (m == 0) ? re0 : re1;
        logic [ACC_W-1:0] aim = (m == 0) ? im0 : im1;
        rep_obs[m] += int'(av);
        // R5: strobe due 4 edges after the claiming sample
        chk(av == e_v[m][slot], "R5", $sformatf("out_valid m%0d phase %s", m, phase),
            64'(av), 64'(e_v[m][slot]));
        if (av && e_v[m][slot]) begin
            chk(ab == e_bin[m][slot], "R1", $sformatf("out_bin m%0d", m), 64'(ab), 64'(e_bin[m][slot]));
            chk(are == e_re[m][slot], "R2", $sformatf("out_re m%0d phase %s", m, phase),
                64'(are), 64'(e_re[m][slot]));
            if (m == 0)
                chk(aim == e_im[m][slot], "R2", $sformatf("out_im cross phase %s", phase),
                    64'(aim), 64'(e_im[m][slot]));
        end
        if (m == 1 && av)
            chk(aim == '0, "R8", "auto out_im", 64'(aim), 64'(0));
    endtask

    task automatic step(input bit v, input bit s);
        @(negedge clk);
        if (j >= 4) begin
            compare(0, (j - 4) % 8);
            compare(1, (j - 4) % 8);
        end
        in_valid = v;
        in_sync  = s;
        ar = rval(); ai = rval(); br = rval(); bi = rval();
        model(0, v, s, j % 8);
        model(1, v, s, j % 8);
        j++;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int base0, base1;
        void'($urandom(32'd20240611));
        for (int m = 0; m < 2; m++) begin
            for (int k = 0; k < 8; k++) e_v[m][k] = 1'b0;
            rep_obs[m] = 0;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10: outputs quiet out of reset
        chk(v0 == 1'b0, "R10", "out_valid cross after reset", 64'(v0), 64'(0));
        chk(v1 == 1'b0, "R10", "out_valid auto after reset", 64'(v1), 64'(0));

        // R4: samples before the first sync are ignored
        phase = "R4";
        for (int i = 0; i < 10; i++) step(1'b1, 1'b0);
        // R3: sync with valid low opens the first interval
        phase = "R3";
        step(1'b0, 1'b1);
        // R11: gaps inside the interval
        phase = "R11";
        for (int i = 0; i < 40; i++) step(($urandom % 3) != 0, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        chk(rep_obs[0] == 0 && rep_obs[1] == 0, "R4", "reports before first close",
            64'(rep_obs[0] + rep_obs[1]), 64'(0));

        // R3: sync together with a valid sample; R6: new totals restart
        phase = "R6";
        step(1'b1, 1'b1);
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
        step(1'b1, 1'b1);
        for (int i = 0; i < 30; i++) step(($urandom % 4) != 0, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        // R9: the 8-bin instance reported every bin
        chk(rep_obs[0] >= 2 * NB0, "R9", "reports at 8 bins", 64'(rep_obs[0]), 64'(2 * NB0));

        // R2: random traffic with extreme operands
        phase = "R2";
        for (int i = 0; i < 2500; i++) step(($urandom % 10) < 7, ($urandom % 60) == 0);

        // R7: only three samples in an interval
        phase = "R7";
        step(1'b0, 1'b1);
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0);
        step(1'b0, 1'b1);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        base0 = rep_obs[0];
        base1 = rep_obs[1];
        for (int i = 0; i < 30; i++) step(1'b1, 1'b0);
        for (int i = 0; i < 6; i++) step(1'b0, 1'b0);
        chk(rep_obs[0] - base0 == 3, "R7", "reports cross", 64'(rep_obs[0] - base0), 64'(3));
        chk(rep_obs[1] - base1 == 3, "R7", "reports auto", 64'(rep_obs[1] - base1), 64'(3));

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule